// File: doc/BRIEF.md
# Quad-data-rate burst SRAM controller

This block sits on the host side of a synchronous SRAM that has a dedicated write-data bus, a dedicated read-data bus and a single shared address bus. The user side offers two independent request channels. Write requests carry four data words, and read requests carry an identifying tag. Both channels use a valid/ready handshake. The controller places read and write addresses on the shared bus in alternating memory-clock phases and drives active-low read and write selects. It streams each four-word write burst as four consecutive beats. It also captures the four beats of every read burst and hands the assembled response back in request order after a fixed latency.

The block runs on one beat clock (`clk`) that has twice the memory clock frequency. An internal four-phase frame counter derives the complementary memory clocks `memK` and `memKn`. These are 180 degrees apart, and each has a rising edge on alternate beats. Frame 0 is the read-address slot, which falls in a true-clock phase. Frame 1 is the write-address slot, which falls in a complementary-clock phase. Because of these fixed slots, a read burst and a write burst can be in flight together and no turnaround cycles are ever inserted. Returning read data is assumed to be already retimed into the beat-clock domain. The alignment of the output clock pair lies outside this block. After reset the controller stays silent for a parameterised start-up delay.

The word width `WORD_W` is 18 by default and 36 in the wide configuration. The burst address width follows from it: 18 bits by default and 17 bits when the width is 36. The read latency `RD_LAT` must be at least 2.

Top module: `qdr_burst_ctrl`

## Requirements
- R1: For the first START_DELAY rising edges after reset release, rdReady and wrReady are 0, memRdN and memWrN are 1, memD is all zero, and memK and memKn are both 0.
- R2: Once started, memK and memKn are always complementary, and each toggles on every beat-clock cycle.
- R3: An accepted read request (rdValid and rdReady both high at an edge) produces exactly one cycle with memRdN low. That cycle is always a memK-high cycle, and memAddr carries the accepted address during it.
- R4: An accepted write request produces exactly one cycle with memWrN low. That cycle is always a memKn-high cycle, and memAddr carries the accepted address during it.
- R5: In the four cycles that follow a write-address cycle, memD carries words 0, 1, 2 and 3 in that order. Word k is wrData[k*WORD_W +: WORD_W]. In every other cycle memD is all zero.
- R6: If memRdN is low in cycle c, the controller samples memQ in cycles c+RD_LAT+k as word k (k = 0 to 3). In cycle c+RD_LAT+4 it raises rspValid for one cycle, with word k in rspData[k*WORD_W +: WORD_W] and rspTag equal to the request's tag.
- R7: After each acceptance the ready of that port falls in the next cycle. Each port issues at most one address in any four consecutive cycles.
- R8: When both ports are kept busy, the issue spacing on each port is exactly four cycles and read issues overlap write data beats. Back-to-back write bursts leave no idle beat between them.
- R9: Responses appear in the order the reads were accepted, and there is exactly one response per accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, twice the memory clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| rdValid | input | 1 | Read request valid |
| rdReady | output | 1 | Read request can be accepted |
| rdAddr | input | ADDR_W | Burst address of the read |
| rdTag | input | TAG_W | Tag returned with the response |
| wrValid | input | 1 | Write request valid |
| wrReady | output | 1 | Write request can be accepted |
| wrAddr | input | ADDR_W | Burst address of the write |
| wrData | input | 4*WORD_W | Four write words, word 0 in the low bits |
| memK | output | 1 | True memory clock |
| memKn | output | 1 | Complementary memory clock |
| memAddr | output | ADDR_W | Shared address bus |
| memRdN | output | 1 | Active-low read-port select |
| memWrN | output | 1 | Active-low write-port select |
| memD | output | WORD_W | Write data beats |
| memQ | input | WORD_W | Read data beats, retimed to clk |
| rspValid | output | 1 | Read response valid, one cycle |
| rspTag | output | TAG_W | Tag of the response |
| rspData | output | 4*WORD_W | Four read words, word 0 in the low bits |

## Verification
The bench drives both channels at full rate at the same time, so every write issue coincides with the last beat of the previous write burst. A controller that gave priority to a freshly loaded burst incorrectly would repeat or lose a beat, and a mis-slotted address would collide with the other port's phase. Read responses are compared against a behavioural memory. A capture window that is off by even one beat would return the words rotated, or mixed with the neighbouring burst. Writes to the top and bottom addresses with all-ones and all-zero data, followed by readback, expose address truncation and word-order swaps. Tags that run past their wrap point expose responses that go out of order or are dropped.

// File: rtl/qdr_burst_pkg.sv
package qdr_burst_pkg;
  localparam int BURST_LEN = 4;
  localparam int FRAME_W = 2;

  typedef struct packed {
    logic running;
    logic [FRAME_W-1:0] frame;
    logic acceptRd;
    logic acceptWr;
    logic issueRd;
    logic issueWr;
    logic driveWr;
  } ctl_strobe_t;
endpackage

// File: rtl/qdr_burst_ctrl_fsm.sv
module qdr_burst_ctrl_fsm
  import qdr_burst_pkg::*;
#(
  parameter int START_DELAY = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdValid,
  input  logic        wrValid,
  output logic        rdReady,
  output logic        wrReady,
  output ctl_strobe_t str
);
  localparam int CNT_W = $clog2(START_DELAY + 1);
  localparam int BEAT_W = $clog2(BURST_LEN + 1);

  logic [CNT_W-1:0]   startCnt;
  logic               running;
  logic [FRAME_W-1:0] frameQ;
  logic               rdPendQ;
  logic               wrPendQ;
  logic [BEAT_W-1:0]  beatsLeft;
  logic               acceptRd;
  logic               acceptWr;
  logic               issueRd;
  logic               issueWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startCnt <= '0;
      running  <= 1'b0;
    end else if (!running) begin
      startCnt <= startCnt + 1'b1;
      running  <= (startCnt == CNT_W'(START_DELAY - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) frameQ <= '0;
    else if (running) frameQ <= frameQ + 1'b1;
  end

  assign rdReady  = running && !rdPendQ;
  assign wrReady  = running && !wrPendQ;
  assign acceptRd = rdValid && rdReady;
  assign acceptWr = wrValid && wrReady;
  assign issueRd  = rdPendQ && (frameQ == FRAME_W'(0));
  assign issueWr  = wrPendQ && (frameQ == FRAME_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPendQ <= 1'b0;
      wrPendQ <= 1'b0;
    end else begin
      if (issueRd) rdPendQ <= 1'b0;
      else if (acceptRd) rdPendQ <= 1'b1;
      if (issueWr) wrPendQ <= 1'b0;
      else if (acceptWr) wrPendQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) beatsLeft <= '0;
    else if (issueWr) beatsLeft <= BEAT_W'(BURST_LEN);
    else if (beatsLeft != '0) beatsLeft <= beatsLeft - 1'b1;
  end

  always_comb begin
    str.running  = running;
    str.frame    = frameQ;
    str.acceptRd = acceptRd;
    str.acceptWr = acceptWr;
    str.issueRd  = issueRd;
    str.issueWr  = issueWr;
    str.driveWr  = (beatsLeft != '0);
  end

  // R7: ready drops right after an acceptance
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    acceptRd |=> !rdReady);
  // R7: read issue spacing of at least four cycles
  p_rd_spacing_r7: assert property (@(posedge clk) disable iff (!rstN)
    issueRd |=> !issueRd ##1 !issueRd ##1 !issueRd);
  p_wr_spacing_r7: assert property (@(posedge clk) disable iff (!rstN)
    issueWr |=> !issueWr ##1 !issueWr ##1 !issueWr);
  // R5: a write issue is followed by four driven beats
  p_wr_burst_r5: assert property (@(posedge clk) disable iff (!rstN)
    issueWr |=> str.driveWr ##1 str.driveWr ##1 str.driveWr ##1 str.driveWr);
endmodule

// File: rtl/qdr_burst_datapath.sv
module qdr_burst_datapath
  import qdr_burst_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int ADDR_W = 18,
  parameter int TAG_W  = 4,
  parameter int RD_LAT = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctl_strobe_t                 str,
  input  logic [ADDR_W-1:0]           rdAddr,
  input  logic [TAG_W-1:0]            rdTag,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [BURST_LEN*WORD_W-1:0] wrData,
  output logic                        memK,
  output logic                        memKn,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        memRdN,
  output logic                        memWrN,
  output logic [WORD_W-1:0]           memD,
  input  logic [WORD_W-1:0]           memQ,
  output logic                        rspValid,
  output logic [TAG_W-1:0]            rspTag,
  output logic [BURST_LEN*WORD_W-1:0] rspData
);
  localparam int PIPE_N = RD_LAT + BURST_LEN;

  logic [ADDR_W-1:0] rdAddrQ;
  logic [TAG_W-1:0]  rdTagQ;
  logic [ADDR_W-1:0] wrAddrQ;
  logic [WORD_W-1:0] wrStage [BURST_LEN];
  logic [WORD_W-1:0] wrBurst [BURST_LEN];
  logic [WORD_W-1:0] capQ    [BURST_LEN];
  logic              pipeVld [PIPE_N];
  logic [TAG_W-1:0]  pipeTag [PIPE_N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddrQ <= '0;
      rdTagQ  <= '0;
      wrAddrQ <= '0;
    end else begin
      if (str.acceptRd) begin
        rdAddrQ <= rdAddr;
        rdTagQ  <= rdTag;
      end
      if (str.acceptWr) wrAddrQ <= wrAddr;
    end
  end

  for (genvar w = 0; w < BURST_LEN; w++) begin : g_wr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrStage[w] <= '0;
        wrBurst[w] <= '0;
      end else begin
        if (str.acceptWr) wrStage[w] <= wrData[w*WORD_W +: WORD_W];
        if (str.issueWr) wrBurst[w] <= wrStage[w];
        else if (str.driveWr)
          wrBurst[w] <= (w == BURST_LEN - 1) ? '0 : wrBurst[(w + 1) % BURST_LEN];
      end
    end
  end

  assign memK    = str.running && !str.frame[0];
  assign memKn   = str.running && str.frame[0];
  assign memRdN  = !str.issueRd;
  assign memWrN  = !str.issueWr;
  assign memD    = str.driveWr ? wrBurst[0] : '0;
  assign memAddr = str.issueRd ? rdAddrQ : (str.issueWr ? wrAddrQ : '0);

  for (genvar w = 0; w < BURST_LEN; w++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rstN) capQ[w] <= '0;
      else capQ[w] <= (w == BURST_LEN - 1) ? memQ : capQ[(w + 1) % BURST_LEN];
    end
    assign rspData[w*WORD_W +: WORD_W] = capQ[w];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeVld[0] <= 1'b0;
      pipeTag[0] <= '0;
    end else begin
      pipeVld[0] <= str.issueRd;
      pipeTag[0] <= rdTagQ;
    end
  end

  for (genvar s = 1; s < PIPE_N; s++) begin : g_pipe
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pipeVld[s] <= 1'b0;
        pipeTag[s] <= '0;
      end else begin
        pipeVld[s] <= pipeVld[s-1];
        pipeTag[s] <= pipeTag[s-1];
      end
    end
  end

  assign rspValid = pipeVld[PIPE_N-1];
  assign rspTag   = pipeTag[PIPE_N-1];

  // R1: silent until start-up completes
  p_idle_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    !str.running |-> memRdN && memWrN && (memD == '0) && !memK && !memKn);
  // R2: clocks complementary and toggling
  p_clk_compl_r2: assert property (@(posedge clk) disable iff (!rstN)
    memK |=> memKn && !memK);
  // R3: read address only in the true-clock read slot
  p_rd_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memRdN |-> memK && (str.frame == FRAME_W'(0)));
  // R4: write address only in the complementary-clock slot
  p_wr_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memWrN |-> memKn && memRdN);
endmodule

// File: rtl/qdr_burst_ctrl.sv
module qdr_burst_ctrl
  import qdr_burst_pkg::*;
#(
  parameter int WORD_W      = 18,
  parameter int ADDR_W      = (WORD_W == 36) ? 17 : 18,
  parameter int TAG_W       = 4,
  parameter int RD_LAT      = 2,
  parameter int START_DELAY = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rdValid,
  output logic                        rdReady,
  input  logic [ADDR_W-1:0]           rdAddr,
  input  logic [TAG_W-1:0]            rdTag,
  input  logic                        wrValid,
  output logic                        wrReady,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [BURST_LEN*WORD_W-1:0] wrData,
  output logic                        memK,
  output logic                        memKn,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        memRdN,
  output logic                        memWrN,
  output logic [WORD_W-1:0]           memD,
  input  logic [WORD_W-1:0]           memQ,
  output logic                        rspValid,
  output logic [TAG_W-1:0]            rspTag,
  output logic [BURST_LEN*WORD_W-1:0] rspData
);
  ctl_strobe_t str;

  qdr_burst_ctrl_fsm #(.START_DELAY(START_DELAY)) ctrl_i (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .wrValid(wrValid),
    .rdReady(rdReady), .wrReady(wrReady), .str(str)
  );

  qdr_burst_datapath #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .RD_LAT(RD_LAT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .str(str),
    .rdAddr(rdAddr), .rdTag(rdTag), .wrAddr(wrAddr), .wrData(wrData),
    .memK(memK), .memKn(memKn), .memAddr(memAddr), .memRdN(memRdN),
    .memWrN(memWrN), .memD(memD), .memQ(memQ),
    .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData)
  );
endmodule

// File: tb/qdr_burst_ctrl_tb_top.sv
module qdr_burst_ctrl_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int WORD_W      = 18;
  localparam int ADDR_W      = 18;
  localparam int TAG_W       = 4;
  localparam int RD_LAT      = 2;
  localparam int START_DELAY = 16;
  localparam int DATA_W      = 4 * WORD_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdValid = 1'b0, wrValid = 1'b0;
  logic rdReady, wrReady;
  logic [ADDR_W-1:0] rdAddr = '0, wrAddr = '0;
  logic [TAG_W-1:0]  rdTag = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic memK, memKn, memRdN, memWrN;
  logic [ADDR_W-1:0] memAddr;
  logic [WORD_W-1:0] memD;
  logic [WORD_W-1:0] memQ = '0;
  logic rspValid;
  logic [TAG_W-1:0]  rspTag;
  logic [DATA_W-1:0] rspData;

  int checks = 0, errors = 0;
  int cycleCnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qdr_burst_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
                   .RD_LAT(RD_LAT), .START_DELAY(START_DELAY)) dut_i (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .rdReady(rdReady),
    .rdAddr(rdAddr), .rdTag(rdTag), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .memK(memK), .memKn(memKn),
    .memAddr(memAddr), .memRdN(memRdN), .memWrN(memWrN), .memD(memD),
    .memQ(memQ), .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < 4; k++)
      r[k*WORD_W +: WORD_W] = WORD_W'(a) * WORD_W'(5) + WORD_W'(k * 3) + WORD_W'('h2b1);
    return r;
  endfunction

  typedef struct { logic [TAG_W-1:0] tag; logic [DATA_W-1:0] data; } rsp_t;
  rsp_t              rspExpQ[$];
  logic [ADDR_W-1:0] rdAddrExpQ[$];
  logic [ADDR_W-1:0] wrAddrExpQ[$];
  logic [DATA_W-1:0] wrDataExpQ[$];
  logic [DATA_W-1:0] shadow[logic [ADDR_W-1:0]];
  logic [DATA_W-1:0] memArr[logic [ADDR_W-1:0]];
  int rdAccepted = 0, rspSeen = 0;

  // behavioural memory
  logic [WORD_W-1:0] beatQ[RD_LAT+2];
  int wrLeft = 0;
  logic [ADDR_W-1:0] wrA;
  logic [DATA_W-1:0] wrBuf;

  initial for (int i = 0; i < RD_LAT + 2; i++) beatQ[i] = '0;

  always @(posedge clk) begin
    logic [DATA_W-1:0] rd;
    logic [DATA_W-1:0] expW;
    cycleCnt++;
    if (wrLeft > 0) begin
      wrBuf[(4 - wrLeft)*WORD_W +: WORD_W] = memD;
      wrLeft--;
      if (wrLeft == 0) begin
        memArr[wrA] = wrBuf;
        expW = (wrDataExpQ.size() > 0) ? wrDataExpQ.pop_front() : '0;
        check(wrBuf == expW, "R5", "write beats word0..3", 128'(wrBuf), 128'(expW));
      end
    end
    if (!memWrN) begin
      wrA = memAddr;
      wrLeft = 4;
    end
    memQ <= beatQ[0];
    for (int i = 0; i < RD_LAT + 1; i++) beatQ[i] <= beatQ[i+1];
    beatQ[RD_LAT+1] <= '0;
    if (!memRdN) begin
      rd = memArr.exists(memAddr) ? memArr[memAddr] : pat(memAddr);
      for (int k = 0; k < 4; k++) beatQ[RD_LAT + k - 2] <= rd[k*WORD_W +: WORD_W];
    end
  end

  // monitor
  bit started = 0, prevK = 0;
  bit streamPhase = 0;
  int lastRd = -1, lastWr = -1, overlapCnt = 0;

  always @(negedge clk) begin
    rsp_t e;
    logic [ADDR_W-1:0] ea;
    if (rstN) begin
      if (started)
        check(memK != memKn && memK != prevK, "R2", "clock pair", {memK, memKn}, {!prevK, prevK});
      if (memK || memKn) started = 1;
      prevK = memK;
      if (!memRdN) begin
        ea = (rdAddrExpQ.size() > 0) ? rdAddrExpQ.pop_front() : '1;
        check(memK && memAddr == ea, "R3", "read address slot", {memK, memAddr}, {1'b1, ea});
        if (streamPhase) begin
          if (lastRd >= 0) check(cycleCnt - lastRd == 4, "R8", "read spacing", cycleCnt - lastRd, 4);
          if (wrLeft > 0) overlapCnt++;
          lastRd = cycleCnt;
        end
      end
      if (!memWrN) begin
        ea = (wrAddrExpQ.size() > 0) ? wrAddrExpQ.pop_front() : '1;
        check(memKn && memAddr == ea, "R4", "write address slot", {memKn, memAddr}, {1'b1, ea});
        if (streamPhase) begin
          if (lastWr >= 0) check(cycleCnt - lastWr == 4, "R8", "write spacing", cycleCnt - lastWr, 4);
          lastWr = cycleCnt;
        end
      end
      if (wrLeft == 0) check(memD == '0, "R5", "memD idle zero", memD, 0);
      else if (streamPhase && wrLeft == 1 && lastWr >= 0)
        check(!memWrN || wrAddrExpQ.size() == 0, "R8", "gapless write issue", memWrN, 0);
      if (rspValid) begin
        rspSeen++;
        if (rspExpQ.size() == 0) check(0, "R9", "unexpected response", rspTag, 0);
        else begin
          e = rspExpQ.pop_front();
          check(rspTag == e.tag, "R9", "response tag order", rspTag, e.tag);
          check(rspData == e.data, "R6", "response data", 128'(rspData), 128'(e.data));
        end
      end
    end
  end

  int tagCnt = 0;

  task automatic doRead(input logic [ADDR_W-1:0] a);
    rsp_t e;
    rdValid = 1; rdAddr = a; rdTag = TAG_W'(tagCnt);
    while (!rdReady) @(negedge clk);
    e.tag = TAG_W'(tagCnt);
    e.data = shadow.exists(a) ? shadow[a] : pat(a);
    rspExpQ.push_back(e);
    rdAddrExpQ.push_back(a);
    tagCnt++; rdAccepted++;
    @(negedge clk);
    check(!rdReady, "R7", "rdReady drops after accept", rdReady, 0);
    rdValid = 0;
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wrValid = 1; wrAddr = a; wrData = d;
    while (!wrReady) @(negedge clk);
    shadow[a] = d;
    wrAddrExpQ.push_back(a);
    wrDataExpQ.push_back(d);
    @(negedge clk);
    check(!wrReady, "R7", "wrReady drops after accept", wrReady, 0);
    wrValid = 0;
  endtask

  task automatic settle();
    repeat (RD_LAT + 16) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    for (int i = 0; i < START_DELAY - 1; i++) begin
      check(!rdReady && !wrReady && memRdN && memWrN && memD == '0 && !memK && !memKn,
            "R1", "idle during start-up",
            {rdReady, wrReady, memRdN, memWrN, memK, memKn, memD}, {4'b0011, 2'b00, 18'h0});
      @(negedge clk);
    end
    for (int i = 0; i < 8 && !rdReady; i++) @(negedge clk);
    check(rdReady && wrReady, "R1", "ready after start-up", {rdReady, wrReady}, 2'b11);

    doRead(18'd5); settle();                                   // unwritten
    doWrite(18'd5, {18'h3_0004, 18'h2_0003, 18'h1_0002, 18'h0_0001}); settle();
    doRead(18'd5); settle();
    doWrite('1, '1); settle();
    doWrite('0, '0); settle();
    doRead('1); doRead('0); settle();

    streamPhase = 1;
    fork
      for (int i = 0; i < 8; i++) doWrite(18'(100 + i), {4{18'(i * 'h111 + 7)}} ^ 72'h5a5a5);
      for (int i = 0; i < 8; i++) doRead(18'(200 + i));
    join
    settle();
    streamPhase = 0;
    check(overlapCnt > 0, "R8", "read issue during write beats", overlapCnt, 1);

    for (int i = 0; i < 12; i++) doRead(18'(100 + (i % 8)));   // tags wrap
    settle();
    check(rspExpQ.size() == 0 && rspSeen == rdAccepted, "R9", "one response per read",
          rspSeen, rdAccepted);
    check(wrDataExpQ.size() == 0, "R5", "all write bursts seen", wrDataExpQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule